// File: doc/BRIEF.md
# Loop Iteration Credit Throttle

This block bounds how many iterations of a dataflow loop may be in flight at the same time. It holds a pool of `CREDITS` tokens. Each new iteration needs one token, which the first instruction of the loop body takes as one extra operand before it can fire. A token goes back into the pool when the last instruction of the body reports that its iteration has finished. A reset fills the pool to its full size.

A request on `start_req` is granted on `start_gnt` in the same cycle when a token is available. A token that returns in that same cycle also counts as available. Each grant carries an iteration number on `gnt_iter`, which the loop uses as the iteration field of its token tags. This number counts up by one for each grant and wraps modulo 2^`ITER_W`. A completion report that would push the pool above its size is flagged on `done_err` and otherwise dropped.

Top module: `iter_throttle`

## Requirements
- R1: After reset the pool holds `CREDITS` tokens, `gnt_iter` is 0, and `start_gnt` and `done_err` are low while no inputs are asserted.
- R2: When the pool is not empty, `start_req` high gives `start_gnt` high in the same cycle, and one token is removed from the pool.
- R3: After `CREDITS` grants with no completion, the next requests see `start_gnt` low and are held for as long as no `iter_done` arrives.
- R4: While the pool is empty, a request is granted in the same cycle that `iter_done` is high.
- R5: `start_req` and `iter_done` together in one cycle produce a grant and leave the pool size unchanged.
- R6: `gnt_iter` shows the number of the next grant. After each grant it becomes the previous value plus 1 modulo 2^`ITER_W`.
- R7: `iter_done` with the pool full and no grant in that cycle raises `done_err` in the same cycle. The pool stays at `CREDITS`, so exactly `CREDITS` further grants are possible before requests are held.
- R8: `iter_done` with the pool not full returns one token and keeps `done_err` low.
- R9: `gnt_iter` does not change in a cycle without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, fills the pool |
| start_req | input | 1 | A new iteration asks for a token |
| start_gnt | output | 1 | Token granted this cycle |
| gnt_iter | output | ITER_W | Iteration number carried by the grant |
| iter_done | input | 1 | Last body instruction finished an iteration |
| done_err | output | 1 | Completion report dropped because the pool was full |

## Verification
A token count that is off by one shows at the ports as an extra or missing grant. This becomes visible no later than the next run of requests that drains the pool, or as a false or missing `done_err` once the pool is refilled. A faulty iteration counter shows as a wrong `gnt_iter` on the very next grant. The bench keeps its own token count and iteration number, and compares grant, error and number in every cycle of the directed sequences and of a long random mix of requests and completions.

// File: rtl/iter_throttle_pkg.sv
package iter_throttle_pkg;

    typedef struct packed {
        logic take;    // a token leaves the pool
        logic give;    // a token returns to the pool
        logic reject;  // a completion report is dropped
    } credit_op_t;

    function automatic credit_op_t decide_op(
        input logic req,
        input logic done,
        input logic has_credit,
        input logic pool_full
    );
        credit_op_t op;
        op.take   = req && (has_credit || done);
        op.reject = done && pool_full && !op.take;
        op.give   = done && !op.reject;
        return op;
    endfunction

endpackage

// File: rtl/credit_pool.sv
module credit_pool
    import iter_throttle_pkg::*;
#(
    parameter int CREDITS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  credit_op_t op,
    output logic       has_credit,
    output logic       pool_full
);
    localparam int CNT_W = $clog2(CREDITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CREDITS);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= FULL;
        end else begin
            case ({op.take, op.give})
                2'b10:   count_q <= count_q - CNT_W'(1);
                2'b01:   count_q <= count_q + CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign has_credit = (count_q != '0);
    assign pool_full  = (count_q == FULL);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL);

    assert_reset_full_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> count_q == FULL);

    assert_take_drops_R2: assert property (@(posedge clk) disable iff (rst)
        (op.take && !op.give) |=> count_q == $past(count_q) - CNT_W'(1));

    assert_pair_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (op.take && op.give) |=> $stable(count_q));

    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        op.reject |=> $stable(count_q));

    assert_no_take_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && op.take) |-> op.give);
endmodule

// File: rtl/iter_seq.sv
module iter_seq #(
    parameter int ITER_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ITER_W-1:0] iter
);
    logic [ITER_W-1:0] iter_q;

    always_ff @(posedge clk) begin
        if (rst)          iter_q <= '0;
        else if (advance) iter_q <= iter_q + ITER_W'(1);
    end

    assign iter = iter_q;

    assert_iter_step_R6: assert property (@(posedge clk) disable iff (rst)
        advance |=> iter_q == $past(iter_q) + ITER_W'(1));

    assert_iter_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(iter_q));
endmodule

// File: rtl/iter_throttle.sv
module iter_throttle
    import iter_throttle_pkg::*;
#(
    parameter int CREDITS = 4,
    parameter int ITER_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    output logic              start_gnt,
    output logic [ITER_W-1:0] gnt_iter,
    input  logic              iter_done,
    output logic              done_err
);
    logic       has_credit;
    logic       pool_full;
    credit_op_t op;

    always_comb begin
        op = decide_op(start_req, iter_done, has_credit, pool_full);
    end

    credit_pool #(.CREDITS(CREDITS)) u_pool (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .has_credit (has_credit),
        .pool_full  (pool_full)
    );

    iter_seq #(.ITER_W(ITER_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .advance (op.take),
        .iter    (gnt_iter)
    );

    assign start_gnt = op.take;
    assign done_err  = op.reject;

    assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        start_gnt |-> start_req);

    assert_err_source_R7: assert property (@(posedge clk) disable iff (rst)
        done_err |-> (iter_done && !start_gnt));

    assert_held_when_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (start_req && !start_gnt) |-> (!iter_done && !has_credit));
endmodule

// File: tb/iter_throttle_bench.sv
`timescale 1ns/1ps
module iter_throttle_bench;
    localparam int K = 3;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_req = 1'b0;
    logic         iter_done = 1'b0;
    logic         start_gnt;
    logic         done_err;
    logic [W-1:0] gnt_iter;

    int checks = 0;
    int errors = 0;
    int m_cnt  = K;
    int m_iter = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    iter_throttle #(.CREDITS(K), .ITER_W(W)) u_iter_throttle (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .start_gnt (start_gnt),
        .gnt_iter  (gnt_iter),
        .iter_done (iter_done),
        .done_err  (done_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic req, input logic done);
        logic eg, ee;
        string gtag, etag;
        @(negedge clk);
        start_req = req;
        iter_done = done;
        #2;
        eg = req && (m_cnt != 0 || done);
        ee = done && (m_cnt == K) && !eg;
        if (req && done)          gtag = "R5";
        else if (eg && m_cnt == 0) gtag = "R4";
        else if (req && !eg)      gtag = "R3";
        else                      gtag = "R2";
        etag = (done && m_cnt == K) ? "R7" : "R8";
        check(gtag, start_gnt, eg);
        check(etag, done_err, ee);
        check(eg ? "R6" : "R9", gnt_iter, m_iter);
        m_cnt = m_cnt - int'(eg) + int'(done && !ee);
        if (eg) m_iter = (m_iter + 1) % (1 << W);
    endtask

    initial begin
        #4000000;
        if (!ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: idle state after reset
        check("R1", start_gnt, 0);
        check("R1", done_err, 0);
        check("R1", gnt_iter, 0);

        // R2/R3: drain the pool, then requests are held
        for (int i = 0; i < K; i++) step(1, 0);
        for (int i = 0; i < 4; i++) step(1, 0);
        // R4: bypass grant while empty
        step(1, 1);
        // R5: pair while partly filled
        step(0, 1);
        step(1, 1);
        // R8: refill the pool
        for (int i = 0; i < K; i++) step(0, 1);
        // R7: excess completions are dropped
        step(0, 1);
        step(0, 1);
        // R7: exactly K grants remain
        for (int i = 0; i < K + 2; i++) step(1, 0);
        for (int i = 0; i < K; i++) step(0, 1);

        // R6 wrap and mixed traffic
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0));
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)));

        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule